// File: doc/BRIEF.md
# Legacy Interrupt Message Requester

This block turns a level-style interrupt line from application logic into legacy interrupt message requests for a PCI Express transmit path. An interrupt line that goes high produces a request for an "assert INTA" message. An interrupt line that goes low produces a request for a "deassert INTA" message. Each request goes to a transmit arbiter over a valid/ready handshake. The interrupt line may be asynchronous, so it first passes through a chain of synchronizer flops.

Two configuration bits gate the block: the interrupt-disable bit of the command register and the MSI enable bit. The block keeps a record of the interrupt state last reported upstream. It never reports the same state twice in a row. If gating switches on while an assert is outstanding upstream, the block reports a deassert. While a request waits for acceptance, later edges of the line are not queued. Once the request is accepted, the record is compared with the current level, so any rise/fall pair that happened in the meantime collapses to nothing.

Back-pressure rules: while `req_valid_o` is high and `req_ready_i` is low, the request and its payload stay unchanged. A transfer happens on a clock edge where both are high. After a transfer the block drops valid for at least one cycle.

Top module: `intx_msg_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `req_valid_o` is 0 and the reported state is "deasserted".
- R2: With gating open and the requester idle, a change of `irq_level_i` from 0 to 1 raises `req_valid_o` on the third rising clock edge after the change, with `req_code_o` = 8'h20 (assert INTA). Exactly one such request follows.
- R3: With gating open, a change of `irq_level_i` from 1 to 0 after an accepted assert produces exactly one request with `req_code_o` = 8'h24 (deassert INTA).
- R4: While `cmd_int_dis_i` is 1, a rising `irq_level_i` produces no request.
- R5: While `msi_en_i` is 1, a rising `irq_level_i` produces no request.
- R6: If gating becomes active while the reported state is "asserted", one 8'h24 request follows. When gating reopens with the line still high, one 8'h20 request follows. This also holds when gating switches on in the same cycle as the acceptance of an assert.
- R7: While `req_valid_o` = 1 and `req_ready_i` = 0, `req_valid_o` stays 1 and `req_code_o` stays unchanged in the next cycle.
- R8: Accepted requests alternate between 8'h20 and 8'h24, starting with 8'h20. A fall followed by a rise of the line while an assert request is still waiting adds no further request.
- R9: `req_route_o` is 3'b100 (local routing) whenever `req_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_level_i | input | 1 | Application interrupt status level (asynchronous) |
| cmd_int_dis_i | input | 1 | Interrupt-disable bit of the command register |
| msi_en_i | input | 1 | MSI enable bit |
| req_valid_o | output | 1 | Message request valid |
| req_ready_i | input | 1 | Arbiter accepts the request |
| req_code_o | output | 8 | Message code: 8'h20 assert, 8'h24 deassert |
| req_route_o | output | 3 | Routing field, always 3'b100 |

## Verification
Two functions can fall in the same cycle. The first is the acceptance of a pending assert request. The second is a change of the gating inputs or the line that requires the opposite report. The bench holds an assert request under back-pressure, then releases `req_ready_i` and sets `cmd_int_dis_i` on the same falling edge. A scoreboard then expects an accepted 8'h20 followed by exactly one 8'h24. The collapse of a rise/fall pair under back-pressure is checked the same way: the scoreboard expects only the single pending assert.

// File: rtl/intx_pkg.sv
package intx_pkg;
  typedef enum logic [7:0] {
    MSG_ASSERT_A   = 8'h20,
    MSG_DEASSERT_A = 8'h24
  } intx_code_e;

  localparam logic [2:0] ROUTE_LOCAL = 3'b100;
endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/intx_gate.sv
module intx_gate (
  input  logic level_i,
  input  logic int_dis_i,
  input  logic msi_en_i,
  output logic want_up_o
);
  logic legacy_open;

  always_comb begin
    legacy_open = !int_dis_i && !msi_en_i;
    want_up_o   = level_i && legacy_open;
  end
endmodule

// File: rtl/intx_issuer.sv
module intx_issuer
  import intx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_up_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] code_o,
  output logic [2:0] route_o
);
  intx_code_e code_q;
  logic       valid_q;
  logic       shown_up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      code_q     <= MSG_DEASSERT_A;
      shown_up_q <= 1'b0;
    end else if (valid_q) begin
      if (ready_i) begin
        valid_q    <= 1'b0;
        shown_up_q <= (code_q == MSG_ASSERT_A);
      end
    end else if (want_up_i != shown_up_q) begin
      valid_q <= 1'b1;
      code_q  <= want_up_i ? MSG_ASSERT_A : MSG_DEASSERT_A;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;
  assign route_o = ROUTE_LOCAL;
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_level_i,
  input  logic       cmd_int_dis_i,
  input  logic       msi_en_i,
  output logic       req_valid_o,
  input  logic       req_ready_i,
  output logic [7:0] req_code_o,
  output logic [2:0] req_route_o
);
  logic level_sync;
  logic want_up;

  intx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_level_i),
    .q_o   (level_sync)
  );

  intx_gate u_gate (
    .level_i   (level_sync),
    .int_dis_i (cmd_int_dis_i),
    .msi_en_i  (msi_en_i),
    .want_up_o (want_up)
  );

  intx_issuer u_issuer (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_up_i (want_up),
    .ready_i   (req_ready_i),
    .valid_o   (req_valid_o),
    .code_o    (req_code_o),
    .route_o   (req_route_o)
  );
endmodule

// File: rtl/intx_msg_chk.sv
module intx_msg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_int_dis_i,
  input logic       msi_en_i,
  input logic       req_valid_o,
  input logic       req_ready_i,
  input logic [7:0] req_code_o,
  input logic [2:0] req_route_o
);
  logic last_up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_up_q <= 1'b0;
    else if (req_valid_o && req_ready_i) last_up_q <= (req_code_o == 8'h20);
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_idle_chk: assert (!req_valid_o);
    end
  end

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_code_o));

  // R9
  route_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_route_o == 3'b100);

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_code_o == 8'h20 || req_code_o == 8'h24));

  // R8
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |-> ((req_code_o == 8'h20) != last_up_q));

  // R4
  gated_no_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) && $past(cmd_int_dis_i || msi_en_i) |-> req_code_o == 8'h24);
endmodule

bind intx_msg_gen intx_msg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_int_dis_i (cmd_int_dis_i),
  .msi_en_i      (msi_en_i),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_code_o    (req_code_o),
  .req_route_o   (req_route_o)
);

// File: tb/sim_intx_msg_gen.sv
`timescale 1ns/1ps
module sim_intx_msg_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq = 1'b0;
  logic       dis = 1'b0;
  logic       msi = 1'b0;
  logic       rdy = 1'b0;
  logic       vld;
  logic [7:0] code;
  logic [2:0] route;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      exp_tag[$];

  always #4 clk = ~clk;

  intx_msg_gen u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_level_i   (irq),
    .cmd_int_dis_i (dis),
    .msi_en_i      (msi),
    .req_valid_o   (vld),
    .req_ready_i   (rdy),
    .req_code_o    (code),
    .req_route_o   (route)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_msg(input logic [7:0] c, input string req);
    exp_q.push_back(c);
    exp_tag.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares every handshake against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && vld && rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected request", code, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = exp_tag.pop_front();
        check(code == e, t, code, e);
        check(route == 3'b100, "R9 route", route, 3'b100);
      end
    end
  end

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    #1;
    check(vld == 1'b0, "R1 valid in reset", vld, 0);
    rst_n = 1'b1;
    idle(4);
    #1;
    check(vld == 1'b0, "R1 valid after reset", vld, 0);

    // R2 latency and code
    rdy = 1'b1;
    expect_msg(8'h20, "R2 assert code");
    irq = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    check(vld == 1'b0, "R2 valid before third edge", vld, 0);
    @(negedge clk); #1;
    check(vld == 1'b1, "R2 valid on third edge", vld, 1);
    idle(8);

    // R3
    expect_msg(8'h24, "R3 deassert code");
    irq = 1'b0;
    idle(10);

    // R4
    dis = 1'b1; irq = 1'b1;
    idle(10); #1;
    check(vld == 1'b0, "R4 disabled no request", vld, 0);
    irq = 1'b0; idle(5); dis = 1'b0; idle(5);

    // R5
    msi = 1'b1; irq = 1'b1;
    idle(10); #1;
    check(vld == 1'b0, "R5 msi on no request", vld, 0);
    irq = 1'b0; idle(5); msi = 1'b0; idle(5);

    // R6 gating mid-interrupt
    expect_msg(8'h20, "R6 assert before gating");
    irq = 1'b1; idle(10);
    expect_msg(8'h24, "R6 deassert on gating");
    dis = 1'b1; idle(10);
    expect_msg(8'h20, "R6 reassert on ungating");
    dis = 1'b0; idle(10);
    expect_msg(8'h24, "R6 deassert on fall");
    irq = 1'b0; idle(10);

    // R6 gating in acceptance cycle, with R7 hold
    rdy = 1'b0;
    expect_msg(8'h20, "R7 held assert");
    irq = 1'b1; idle(6);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      check(vld == 1'b1 && code == 8'h20, "R7 hold under back-pressure", {vld, code}, {1'b1, 8'h20});
    end
    expect_msg(8'h24, "R6 deassert after same-cycle gating");
    rdy = 1'b1; dis = 1'b1;
    idle(10);
    irq = 1'b0; idle(5); dis = 1'b0; idle(5);

    // R8 coalesce a fall/rise pair under back-pressure
    rdy = 1'b0;
    expect_msg(8'h20, "R8 single assert");
    irq = 1'b1; idle(6);
    irq = 1'b0; idle(6);
    irq = 1'b1; idle(6);
    rdy = 1'b1; idle(10); #1;
    check(vld == 1'b0, "R8 no extra request", vld, 0);
    expect_msg(8'h24, "R8 deassert follows");
    irq = 1'b0; idle(10);

    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule